// File: doc/BRIEF.md
# Predictive Feedforward PID Compensator

This block is the discrete-time control law of a digital buck converter. On each conversion strobe it takes a signed output-voltage error sample and a signed inductor-current-change sample, and it produces a new duty-cycle command for the pulse-width modulator that follows it. The command sums five contributions. Four are feedback terms: proportional, integral, first difference and second difference (jerk) of the error. The fifth is a feedforward term taken from the inductor current change.

No term uses a multiplier. Each contribution is a read from its own 64-entry table of 12-bit signed products. The table is addressed by a 6-bit index that is saturated from the term. Software or a tuning engine fills the five tables through a simple write port, so each gain curve can be shaped freely, including nonlinear shapes.

The integrator has anti-windup clamping. The summed command is limited to the duty range and registered, and a valid pulse marks each new value. One update per strobe matches a converter sample rate of a few MSPS.

Top module: `pfpid_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released, duty_out is 0 and duty_vld is 0. Reset also clears the two-sample error history and the integrator, so the first sample after reset sees zero history.
- R2: The clock edge that samples sample_vld high updates duty_out and raises duty_vld for exactly one cycle. When no strobe is present, duty_vld is 0 and duty_out, the history and the integrator all hold.
- R3: The proportional table (select 0) is read at the 6-bit two's-complement address sat(e[n]), where sat clamps to [-32, 31].
- R4: The derivative table (select 2) is read at sat(e[n] - e[n-1]).
- R5: The jerk table (select 3) is read at sat(e[n] - 2*e[n-1] + e[n-2]).
- R6: The integrator is 12 bits: acc[n] = clamp(acc[n-1] + e[n], -2048, 2047). The integral table (select 1) is read at acc[n] arithmetically shifted right by 6.
- R7: The feedforward table (select 4) is read at sat(ilchg_in).
- R8: duty_out is the sum of the five 12-bit signed table outputs, clamped to [0, 1023].
- R9: A cycle with cfg_we high writes cfg_data into entry cfg_addr of the table picked by cfg_sel, and the new value applies to later samples. cfg_sel values 5 to 7 change no table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Conversion strobe, one cycle per sample |
| err_in | input | 8 | Signed error sample |
| ilchg_in | input | 8 | Signed inductor-current-change sample |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 3 | Table select: 0 P, 1 I, 2 D, 3 jerk, 4 feedforward |
| cfg_addr | input | 6 | Table entry address |
| cfg_data | input | 12 | Signed table entry |
| duty_out | output | 10 | Registered duty command |
| duty_vld | output | 1 | One-cycle pulse marking a new command |

## Verification
The bench fills one table at a time with a distinct ramp and zeroes the others. A wrong index then shows up as a wrong duty value: a missing saturation wraps a large error onto the opposite sign, and a history that shifts on idle cycles corrupts the first and second differences. It drives a long run of full-scale positive errors into the integrator and then a single opposing sample. An integrator without the clamp, or one that wraps, gives the wrong integral entry after that reversal. Random tables and random error and current sequences push the sum both below 0 and above 1023, which catches a missing or one-sided output clamp. Writes with the unused selects 5 to 7 are checked for having no effect on later outputs.

// File: rtl/pfpid_pkg.sv
package pfpid_pkg;
  localparam int TERM_P = 0;
  localparam int TERM_I = 1;
  localparam int TERM_D = 2;
  localparam int TERM_J = 3;
  localparam int TERM_F = 4;
  localparam int NTERM  = 5;

  function automatic logic signed [31:0] clamp_rng(input logic signed [31:0] v,
                                                   input logic signed [31:0] lo,
                                                   input logic signed [31:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // saturate to a w-bit two's-complement range
  function automatic logic signed [31:0] sat_w(input logic signed [31:0] v, input int w);
    logic signed [31:0] lim;
    lim = 32'sd1 <<< (w - 1);
    return clamp_rng(v, -lim, lim - 32'sd1);
  endfunction
endpackage

// File: rtl/pfpid_hist.sv
module pfpid_hist #(
  parameter int EW = 8,
  parameter int IW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [EW-1:0] err_i,
  output logic [IW-1:0]        p_idx_o,
  output logic [IW-1:0]        d_idx_o,
  output logic [IW-1:0]        j_idx_o
);
  import pfpid_pkg::*;

  logic signed [EW-1:0] e1_q, e2_q, e1_d, e2_d;
  logic signed [31:0]   d_w, j_w;

  always_comb begin
    d_w  = 32'(err_i) - 32'(e1_q);
    j_w  = 32'(err_i) - 2 * 32'(e1_q) + 32'(e2_q);
    p_idx_o = IW'(sat_w(32'(err_i), IW));
    d_idx_o = IW'(sat_w(d_w, IW));
    j_idx_o = IW'(sat_w(j_w, IW));
    e1_d = en ? err_i : e1_q;
    e2_d = en ? e1_q  : e2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1_q <= '0;
      e2_q <= '0;
    end else begin
      e1_q <= e1_d;
      e2_q <= e2_d;
    end
  end
endmodule

// File: rtl/pfpid_integ.sv
module pfpid_integ #(
  parameter int EW = 8,
  parameter int AW = 12,
  parameter int IW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [EW-1:0] err_i,
  output logic [IW-1:0]        i_idx_o,
  output logic signed [AW-1:0] acc_o
);
  import pfpid_pkg::*;

  localparam int SHIFT = AW - IW;

  logic signed [AW-1:0] acc_q, acc_sum, acc_d;

  always_comb begin
    acc_sum = AW'(sat_w(32'(acc_q) + 32'(err_i), AW));
    acc_d   = en ? acc_sum : acc_q;
    i_idx_o = IW'(acc_sum >>> SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/pfpid_lut.sv
module pfpid_lut #(
  parameter int IW = 6,
  parameter int PW = 12
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [IW-1:0]        waddr,
  input  logic signed [PW-1:0] wdata,
  input  logic [IW-1:0]        raddr,
  output logic signed [PW-1:0] rdata
);
  localparam int DEPTH = 1 << IW;

  logic signed [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pfpid_ctrl.sv
module pfpid_ctrl #(
  parameter int EW = 8,
  parameter int IW = 6,
  parameter int PW = 12,
  parameter int AW = 12,
  parameter int DW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_vld,
  input  logic signed [EW-1:0] err_in,
  input  logic signed [EW-1:0] ilchg_in,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_sel,
  input  logic [IW-1:0]        cfg_addr,
  input  logic signed [PW-1:0] cfg_data,
  output logic [DW-1:0]        duty_out,
  output logic                 duty_vld
);
  import pfpid_pkg::*;

  localparam int SUMW = PW + $clog2(NTERM) + 1;
  localparam logic signed [SUMW-1:0] DMAX = SUMW'((1 << DW) - 1);

  logic [IW-1:0]        idx_v  [NTERM];
  logic signed [PW-1:0] prod_v [NTERM];
  logic signed [SUMW-1:0] sum_raw;
  logic signed [AW-1:0] integ_acc;
  logic [DW-1:0]        duty_q, duty_d, duty_sat;
  logic                 vld_q;

  pfpid_hist #(.EW(EW), .IW(IW)) u_hist (
    .clk(clk), .rst_n(rst_n), .en(sample_vld), .err_i(err_in),
    .p_idx_o(idx_v[TERM_P]), .d_idx_o(idx_v[TERM_D]), .j_idx_o(idx_v[TERM_J])
  );

  pfpid_integ #(.EW(EW), .AW(AW), .IW(IW)) u_integ (
    .clk(clk), .rst_n(rst_n), .en(sample_vld), .err_i(err_in),
    .i_idx_o(idx_v[TERM_I]), .acc_o(integ_acc)
  );

  assign idx_v[TERM_F] = IW'(sat_w(32'(ilchg_in), IW));

  for (genvar t = 0; t < NTERM; t++) begin : g_lut
    pfpid_lut #(.IW(IW), .PW(PW)) u_lut (
      .clk(clk),
      .we(cfg_we && (cfg_sel == 3'(t))),
      .waddr(cfg_addr),
      .wdata(cfg_data),
      .raddr(idx_v[t]),
      .rdata(prod_v[t])
    );
  end

  always_comb begin
    sum_raw = '0;
    for (int t = 0; t < NTERM; t++) sum_raw = sum_raw + SUMW'(prod_v[t]);
    if (sum_raw < 0)         duty_sat = '0;
    else if (sum_raw > DMAX) duty_sat = DMAX[DW-1:0];
    else                     duty_sat = sum_raw[DW-1:0];
    duty_d = sample_vld ? duty_sat : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      duty_q <= duty_d;
      vld_q  <= sample_vld;
    end
  end

  assign duty_out = duty_q;
  assign duty_vld = vld_q;
endmodule

// File: rtl/pfpid_ctrl_chk.sv
module pfpid_ctrl_chk #(
  parameter int EW = 8,
  parameter int AW = 12,
  parameter int DW = 10,
  parameter int SUMW = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sample_vld,
  input logic signed [EW-1:0]   err_in,
  input logic [DW-1:0]          duty_out,
  input logic                   duty_vld,
  input logic signed [SUMW-1:0] sum_raw,
  input logic signed [AW-1:0]   integ_acc
);
  localparam logic [DW-1:0] DTOP = DW'((1 << DW) - 1);
  localparam logic signed [SUMW-1:0] STOP = SUMW'((1 << DW) - 1);
  localparam logic signed [AW-1:0] AHI = AW'((1 << (AW - 1)) - 1);
  localparam logic signed [AW-1:0] ALO = AW'(-(1 << (AW - 1)));

  // R2
  vld_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty_vld |-> $past(sample_vld));
  // R2
  strobe_gives_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> duty_vld);
  // R2
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> $stable(duty_out));
  // R8
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && sum_raw > STOP) |=> duty_out == DTOP);
  // R8
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && sum_raw < 0) |=> duty_out == '0);
  // R6
  acc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && integ_acc == AHI && err_in >= 0) |=> integ_acc == AHI);
  // R6
  acc_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && integ_acc == ALO && err_in <= 0) |=> integ_acc == ALO);
endmodule

bind pfpid_ctrl pfpid_ctrl_chk #(.EW(EW), .AW(AW), .DW(DW), .SUMW(SUMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .err_in(err_in),
  .duty_out(duty_out), .duty_vld(duty_vld), .sum_raw(sum_raw), .integ_acc(integ_acc)
);

// File: tb/pfpid_ctrl_tb.sv
module pfpid_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_vld = 1'b0;
  logic signed [7:0] err_in = '0;
  logic signed [7:0] ilchg_in = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [5:0] cfg_addr = '0;
  logic signed [11:0] cfg_data = '0;
  logic [9:0] duty_out;
  logic duty_vld;

  int total = 0;
  int bad = 0;
  int tbl [5][64];
  int m_e1, m_e2, m_acc, m_duty;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pfpid_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .err_in(err_in),
    .ilchg_in(ilchg_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .duty_out(duty_out), .duty_vld(duty_vld)
  );

  function automatic int clampi(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int ix(int v);
    return clampi(v, -32, 31) & 63;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 duty in reset", int'(duty_out), 0);
    chk("R1 vld in reset", int'(duty_vld), 0);
    rst_n = 1'b1;
    m_e1 = 0; m_e2 = 0; m_acc = 0; m_duty = 0;
    @(negedge clk);
    chk("R1 duty after reset", int'(duty_out), 0);
  endtask

  task automatic wr(int sel, int addr, int val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = 3'(sel);
    cfg_addr = 6'(addr);
    cfg_data = 12'(val);
    if (sel < 5) tbl[sel][addr] = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // mode 0: zeros, 1: ramp 16k+1, 2: random in [-100, 400]
  task automatic load(int sel, int mode);
    for (int k = 0; k < 64; k++) begin
      int v;
      if (mode == 0)      v = 0;
      else if (mode == 1) v = 16 * k + 1;
      else                v = int'($urandom_range(500)) - 100;
      wr(sel, k, v);
    end
  endtask

  task automatic do_sample(int e, int c, string req);
    int d, j, s;
    d = e - m_e1;
    j = e - 2 * m_e1 + m_e2;
    m_acc = clampi(m_acc + e, -2048, 2047);
    s = tbl[0][ix(e)] + tbl[1][(m_acc >>> 6) & 63] + tbl[2][ix(d)]
      + tbl[3][ix(j)] + tbl[4][ix(c)];
    m_duty = clampi(s, 0, 1023);
    m_e2 = m_e1;
    m_e1 = e;
    @(negedge clk);
    sample_vld = 1'b1;
    err_in = 8'(e);
    ilchg_in = 8'(c);
    @(negedge clk);
    sample_vld = 1'b0;
    chk({req, " vld"}, int'(duty_vld), 1);
    chk(req, int'(duty_out), m_duty);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R2 idle vld", int'(duty_vld), 0);
      chk("R2 idle hold", int'(duty_out), m_duty);
    end
  endtask

  initial begin
    void'($urandom(32'h0005eed1));
    m_e1 = 0; m_e2 = 0; m_acc = 0; m_duty = 0;
    for (int s = 0; s < 5; s++) load(s, 0);
    do_reset();

    // proportional only
    load(0, 1);
    do_sample(0, 0, "R3");
    do_sample(5, 0, "R3");
    do_sample(-1, 0, "R3");
    do_sample(31, 0, "R3");
    do_sample(32, 0, "R3 sat");
    do_sample(100, 0, "R3 sat");
    do_sample(-33, 0, "R3 sat");
    do_sample(-128, 0, "R3 sat");
    do_sample(127, 0, "R3 sat");
    load(0, 0);

    // derivative only; first sample sees cleared history
    load(2, 1);
    do_reset();
    do_sample(20, 0, "R1 first D");
    do_sample(20, 0, "R4");
    idle(3);
    do_sample(-10, 0, "R4");
    do_sample(127, 0, "R4 sat");
    do_sample(-128, 0, "R4 sat");
    do_sample(-100, 0, "R4");
    load(2, 0);

    // jerk only
    load(3, 1);
    do_reset();
    do_sample(7, 0, "R1 first J");
    do_sample(9, 0, "R5");
    do_sample(9, 0, "R5");
    idle(2);
    do_sample(-3, 0, "R5");
    do_sample(100, 0, "R5 sat");
    do_sample(-100, 0, "R5 sat");
    do_sample(-100, 0, "R5");
    load(3, 0);

    // integral only with windup
    load(1, 1);
    do_reset();
    for (int k = 0; k < 25; k++) do_sample(127, 0, "R6 wind up");
    do_sample(-64, 0, "R6 unwind");
    do_sample(-1, 0, "R6");
    for (int k = 0; k < 40; k++) do_sample(-128, 0, "R6 wind down");
    do_sample(64, 0, "R6 unwind");
    idle(2);
    do_sample(3, 0, "R6");
    load(1, 0);

    // feedforward only
    load(4, 1);
    do_sample(0, 13, "R7");
    do_sample(0, -5, "R7");
    do_sample(0, 90, "R7 sat");
    do_sample(0, -90, "R7 sat");
    do_sample(0, 31, "R7");

    // random tables and sequences
    do_reset();
    for (int s = 0; s < 5; s++) load(s, 2);
    for (int k = 0; k < 400; k++) begin
      do_sample(int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128, "R8");
      if ($urandom_range(3) == 0) idle(int'($urandom_range(3)) + 1);
    end

    // unused selects must not alter any table
    wr(5, ix(10), 1500);
    wr(6, ix(0), -1500);
    wr(7, ix(-4), 2000);
    do_sample(10, -4, "R9 unused sel");
    do_sample(0, 0, "R9 unused sel");
    do_sample(-4, 10, "R9 unused sel");
    // real write applies to the next sample
    wr(0, ix(50), 2000);
    do_sample(50, 0, "R9 write");
    wr(4, ix(-7), -2000);
    do_sample(0, -7, "R9 write");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule